// File: doc/BRIEF.md
# Brown-out and Power-up Reset Sequencer

This block decides when the core of a small microcontroller may leave reset. Once the power-on circuit signals that its own delay is over, the block keeps the core in reset until the supply is above the brown-out threshold. It then runs an optional power-up delay. After that it runs an oscillator start-up delay, which is skipped when the clock comes from an external source. Only after these steps does it release the core.

A supply comparator flag is watched through a glitch filter. The supply must stay low for a set number of consecutive cycles before the block treats it as a brown-out. A 2-bit configuration picks how brown-out detection is enabled. When a brown-out is accepted after power-on, the core goes back into reset and the whole delay chain starts again from zero. A sticky flag records that this happened, and software clears it.

Top module: `rst_seq_top`

## Requirements
- R1: While `rst` is high, and after it falls until a `por_done_i` pulse arrives, `core_rst_o` is 1 and `bor_flag_o` is 0, however long the block waits.
- R2: `bor_mode_i` = 2'b00 turns detection off, so a low supply of any length has no effect. `bor_mode_i` = 2'b11 keeps detection on at all times.
- R3: With `bor_mode_i` = 2'b01, detection is on exactly when `sw_bor_en_i` is 1.
- R4: With `bor_mode_i` = 2'b10, detection is on while `sleep_i` is 0 and off while it is 1, and `sw_bor_en_i` has no effect.
- R5: A brown-out is accepted only after `supply_low_i` has been sampled high on TBOR_CYC consecutive clock edges with detection on. A dip of TBOR_CYC-1 edges leaves the core running.
- R6: An accepted brown-out during the power-up delay, the start-up delay or normal running asserts `core_rst_o`. After the supply recovers, the power-up delay runs again in full from zero.
- R7: After the power-on pulse, and after a brown-out, the block stays in reset while detection is on and `supply_low_i` is 1. With detection off it does not wait for the supply.
- R8: With the power-up delay enabled and an internal oscillator, `core_rst_o` falls on the edge 2+PWRT_CYC+OST_CYC edges after the edge that samples `por_done_i`, counting that edge as 1. With the power-up delay disabled, this becomes 2+OST_CYC.
- R9: With `osc_ext_i` = 1, the start-up delay is skipped. With external clock and no power-up delay, `core_rst_o` falls on the second edge after the power-on pulse.
- R10: `bor_flag_o` goes to 1 on an accepted brown-out after power-on, holds until `flag_clr_i` is 1, and a new brown-out wins over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the block sits in its power-on wait state |
| por_done_i | input | 1 | Pulse: power-on reset delay has expired |
| supply_low_i | input | 1 | Comparator flag, high while the supply is below the brown-out threshold |
| bor_mode_i | input | 2 | Detection mode: 00 off, 01 software, 10 awake only, 11 always |
| sw_bor_en_i | input | 1 | Software detection enable, used in mode 01 |
| sleep_i | input | 1 | High while the core sleeps |
| pwrt_en_i | input | 1 | Enables the power-up delay |
| osc_ext_i | input | 1 | High when the clock is external; skips the start-up delay |
| flag_clr_i | input | 1 | Clears the brown-out flag |
| core_rst_o | output | 1 | Registered active-high core reset |
| bor_flag_o | output | 1 | Sticky flag: a brown-out reset occurred |

## Verification
The release sequence is run from the power-on pulse for each pairing of power-up enable and oscillator kind. The measured release edge shows which of the two delays ran, and a vector with a low supply and detection off shows that the block does not wait for the supply. Supply dips one edge shorter than the filter length and exactly as long as it are applied in each detection mode, with the sleep and software inputs set both ways. This shows the gating truth table and the filter boundary. A brown-out partway through the power-up delay is timed from the supply's recovery, which separates a full restart from a resumed count.

// File: rtl/rst_seq_pkg.sv
`timescale 1ns/1ps
package rst_seq_pkg;

  typedef enum logic [1:0] {
    BOR_OFF    = 2'b00,
    BOR_SW     = 2'b01,
    BOR_AWAKE  = 2'b10,
    BOR_ALWAYS = 2'b11
  } bor_mode_e;

  typedef enum logic [2:0] {
    ST_POR  = 3'd0,
    ST_HOLD = 3'd1,
    ST_PWRT = 3'd2,
    ST_OST  = 3'd3,
    ST_RUN  = 3'd4
  } seq_state_e;

endpackage

// File: rtl/rsq_bor_gate.sv
`timescale 1ns/1ps
module rsq_bor_gate
  import rst_seq_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       sw_en_i,
  input  logic       sleep_i,
  output logic       en_o
);
  always_comb begin
    unique case (bor_mode_e'(mode_i))
      BOR_OFF:    en_o = 1'b0;
      BOR_SW:     en_o = sw_en_i;
      BOR_AWAKE:  en_o = ~sleep_i;
      BOR_ALWAYS: en_o = 1'b1;
      default:    en_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/rsq_glitch_filter.sv
`timescale 1ns/1ps
module rsq_glitch_filter #(
  parameter int TBOR_CYC = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic low_i,
  output logic det_o
);
  localparam int CW = $clog2(TBOR_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TBOR_CYC);

  logic [CW-1:0] run_q;

  // count consecutive qualified low samples, saturate at the limit
  always_ff @(posedge clk) begin
    if (rst || !(en_i && low_i)) begin
      run_q <= '0;
    end else if (run_q != LIMIT) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign det_o = (run_q == LIMIT);
endmodule

// File: rtl/rsq_delay_timer.sv
`timescale 1ns/1ps
module rsq_delay_timer #(
  parameter int LEN = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/rsq_fsm.sv
`timescale 1ns/1ps
module rsq_fsm
  import rst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       por_done_i,
  input  logic       low_i,
  input  logic       bor_en_i,
  input  logic       det_i,
  input  logic       pwrt_en_i,
  input  logic       osc_ext_i,
  input  logic       pwrt_done_i,
  input  logic       ost_done_i,
  input  logic       flag_clr_i,
  output seq_state_e state_o,
  output logic       pwrt_run_o,
  output logic       ost_run_o,
  output logic       core_rst_o,
  output logic       flag_o
);
  seq_state_e st_q, st_n;
  logic       rst_q, flag_q;
  logic       live;       // states in which a brown-out is accepted
  seq_state_e after_hold;
  seq_state_e after_pwrt;

  assign live       = (st_q == ST_PWRT) || (st_q == ST_OST) || (st_q == ST_RUN);
  assign after_pwrt = osc_ext_i ? ST_RUN : ST_OST;
  assign after_hold = pwrt_en_i ? ST_PWRT : after_pwrt;

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      ST_POR:  if (por_done_i) st_n = ST_HOLD;
      ST_HOLD: if (!(bor_en_i && low_i)) st_n = after_hold;
      ST_PWRT: begin
        if (det_i)            st_n = ST_HOLD;
        else if (pwrt_done_i) st_n = after_pwrt;
      end
      ST_OST: begin
        if (det_i)           st_n = ST_HOLD;
        else if (ost_done_i) st_n = ST_RUN;
      end
      ST_RUN:  if (det_i) st_n = ST_HOLD;
      default: st_n = ST_POR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_POR;
      rst_q  <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      rst_q <= (st_n != ST_RUN);
      if (det_i && live)   flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign state_o    = st_q;
  assign pwrt_run_o = (st_q == ST_PWRT);
  assign ost_run_o  = (st_q == ST_OST);
  assign core_rst_o = rst_q;
  assign flag_o     = flag_q;
endmodule

// File: rtl/rst_seq_top.sv
`timescale 1ns/1ps
module rst_seq_top
  import rst_seq_pkg::*;
#(
  parameter int TBOR_CYC = 100,
  parameter int PWRT_CYC = 3_200_000,
  parameter int OST_CYC  = 1024
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       por_done_i,
  input  logic       supply_low_i,
  input  logic [1:0] bor_mode_i,
  input  logic       sw_bor_en_i,
  input  logic       sleep_i,
  input  logic       pwrt_en_i,
  input  logic       osc_ext_i,
  input  logic       flag_clr_i,
  output logic       core_rst_o,
  output logic       bor_flag_o
);
  logic       bor_en, det, pwrt_run, ost_run, pwrt_done, ost_done;
  seq_state_e state_q;

  rsq_bor_gate u_gate (
    .mode_i (bor_mode_i),
    .sw_en_i(sw_bor_en_i),
    .sleep_i(sleep_i),
    .en_o   (bor_en)
  );

  rsq_glitch_filter #(.TBOR_CYC(TBOR_CYC)) u_filt (
    .clk  (clk),
    .rst  (rst),
    .en_i (bor_en),
    .low_i(supply_low_i),
    .det_o(det)
  );

  rsq_delay_timer #(.LEN(PWRT_CYC)) u_pwrt (
    .clk   (clk),
    .rst   (rst),
    .run_i (pwrt_run),
    .done_o(pwrt_done)
  );

  rsq_delay_timer #(.LEN(OST_CYC)) u_ost (
    .clk   (clk),
    .rst   (rst),
    .run_i (ost_run),
    .done_o(ost_done)
  );

  rsq_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .por_done_i (por_done_i),
    .low_i      (supply_low_i),
    .bor_en_i   (bor_en),
    .det_i      (det),
    .pwrt_en_i  (pwrt_en_i),
    .osc_ext_i  (osc_ext_i),
    .pwrt_done_i(pwrt_done),
    .ost_done_i (ost_done),
    .flag_clr_i (flag_clr_i),
    .state_o    (state_q),
    .pwrt_run_o (pwrt_run),
    .ost_run_o  (ost_run),
    .core_rst_o (core_rst_o),
    .flag_o     (bor_flag_o)
  );
endmodule

// File: rtl/rst_seq_chk.sv
`timescale 1ns/1ps
module rst_seq_chk
  import rst_seq_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       supply_low_i,
  input logic       flag_clr_i,
  input logic       core_rst_o,
  input logic       bor_flag_o,
  input logic       bor_en,
  input logic       det,
  input seq_state_e state_q
);
  logic live;
  assign live = (state_q == ST_PWRT) || (state_q == ST_OST) || (state_q == ST_RUN);

  p_por_holds_r1: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_POR) |-> (core_rst_o && !bor_flag_o));

  p_off_no_trip_r2: assert property (@(posedge clk) disable iff (rst)
    !bor_en |=> !det);

  p_trip_enters_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (det && live) |=> (state_q == ST_HOLD && core_rst_o));

  p_hold_waits_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HOLD && bor_en && supply_low_i) |=> (state_q == ST_HOLD));

  p_release_only_run_r8: assert property (@(posedge clk) disable iff (rst)
    !core_rst_o |-> (state_q == ST_RUN));

  p_flag_set_r10: assert property (@(posedge clk) disable iff (rst)
    (det && live) |=> bor_flag_o);

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (bor_flag_o && !flag_clr_i) |=> bor_flag_o);
endmodule

bind rst_seq_top rst_seq_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .supply_low_i(supply_low_i),
  .flag_clr_i  (flag_clr_i),
  .core_rst_o  (core_rst_o),
  .bor_flag_o  (bor_flag_o),
  .bor_en      (bor_en),
  .det         (det),
  .state_q     (state_q)
);

// File: tb/rst_seq_top_tb.sv
`timescale 1ns/1ps
module rst_seq_top_tb;
  localparam int TB = 4;
  localparam int P  = 20;
  localparam int O  = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic por_done = 1'b0, low = 1'b0, sw_en = 1'b0, slp = 1'b0;
  logic pwrt_en = 1'b1, ext = 1'b0, fclr = 1'b0;
  logic [1:0] mode = 2'b11;
  logic core_rst, flag;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  rst_seq_top #(.TBOR_CYC(TB), .PWRT_CYC(P), .OST_CYC(O)) u_dut (
    .clk(clk), .rst(rst), .por_done_i(por_done), .supply_low_i(low),
    .bor_mode_i(mode), .sw_bor_en_i(sw_en), .sleep_i(slp),
    .pwrt_en_i(pwrt_en), .osc_ext_i(ext), .flag_clr_i(fclr),
    .core_rst_o(core_rst), .bor_flag_o(flag)
  );

  typedef struct packed {
    logic       pwrt;
    logic       ext;
    logic [1:0] mode;
    logic       low;
    logic [7:0] exp;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{1'b1, 1'b0, 2'b11, 1'b0, 8'd32},  // R8 both delays
    '{1'b0, 1'b0, 2'b11, 1'b0, 8'd12},  // R8 start-up only
    '{1'b1, 1'b1, 2'b11, 1'b0, 8'd22},  // R9 power-up only
    '{1'b0, 1'b1, 2'b01, 1'b0, 8'd2},   // R9 no delay
    '{1'b1, 1'b0, 2'b00, 1'b1, 8'd32}   // R2/R7 low supply ignored when off
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; por_done = 1'b0; low = 1'b0; fclr = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic from_por(output int n);
    @(negedge clk) por_done = 1'b1;
    @(negedge clk) por_done = 1'b0;
    n = 1;
    while (core_rst && n < 200) begin
      @(posedge clk); #1; n++;
    end
  endtask

  task automatic count_release(output int n);
    n = 0;
    while (core_rst && n < 200) begin
      @(posedge clk); #1; n++;
    end
  endtask

  task automatic dip(input int k);
    @(negedge clk) low = 1'b1;
    repeat (k) @(negedge clk);
    low = 1'b0;
    repeat (2) @(posedge clk);
    #1;
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n;
    // R1 reset state and wait for power-on pulse
    repeat (2) @(posedge clk);
    #1 chk(core_rst == 1'b1 && flag == 1'b0, "R1 in reset", core_rst, 1);
    @(negedge clk) rst = 1'b0;
    repeat (50) @(posedge clk);
    #1 chk(core_rst == 1'b1 && flag == 1'b0, "R1 no pulse", core_rst, 1);

    // vector walk: release edge per configuration
    for (int i = 0; i < 5; i++) begin
      do_reset();
      pwrt_en = VEC[i].pwrt; ext = VEC[i].ext; mode = VEC[i].mode; low = VEC[i].low;
      from_por(n);
      chk(n == int'(VEC[i].exp), $sformatf("R8/R9/R2 vec%0d", i), n, VEC[i].exp);
    end
    low = 1'b0;

    // R7 hold while supply low with detection on
    do_reset();
    pwrt_en = 1'b1; ext = 1'b0; mode = 2'b11; low = 1'b1;
    @(negedge clk) por_done = 1'b1;
    @(negedge clk) por_done = 1'b0;
    repeat (40) @(posedge clk);
    #1 chk(core_rst == 1'b1, "R7 hold", core_rst, 1);
    @(negedge clk) low = 1'b0;
    count_release(n);
    chk(n == P + O + 1, "R7 release after recovery", n, P + O + 1);
    chk(flag == 1'b0, "R10 no flag at power-up", flag, 0);

    // R6 brown-out during power-up delay restarts it
    do_reset();
    pwrt_en = 1'b1; ext = 1'b0; mode = 2'b11;
    @(negedge clk) por_done = 1'b1;
    @(negedge clk) por_done = 1'b0;
    repeat (8) @(negedge clk);
    low = 1'b1;
    repeat (8) @(negedge clk);
    #1 chk(core_rst == 1'b1, "R6 in reset", core_rst, 1);
    low = 1'b0;
    count_release(n);
    chk(n == P + O + 1, "R6 full restart", n, P + O + 1);
    chk(flag == 1'b1, "R10 flag set", flag, 1);
    @(negedge clk) fclr = 1'b1;
    @(negedge clk) fclr = 1'b0;
    chk(flag == 1'b0, "R10 flag cleared", flag, 0);

    // filter and mode gating while running
    do_reset();
    pwrt_en = 1'b1; ext = 1'b1; mode = 2'b11; sw_en = 1'b0; slp = 1'b0;
    from_por(n);
    dip(TB - 1);
    chk(core_rst == 1'b0, "R5 short dip", core_rst, 0);
    dip(TB);
    chk(core_rst == 1'b1, "R5 full dip", core_rst, 1);
    count_release(n);

    mode = 2'b00;
    dip(10);
    chk(core_rst == 1'b0 && flag == 1'b1, "R2 off ignores dip", core_rst, 0);
    @(negedge clk) fclr = 1'b1;
    @(negedge clk) fclr = 1'b0;

    mode = 2'b01; sw_en = 1'b0;
    dip(10);
    chk(core_rst == 1'b0 && flag == 1'b0, "R3 sw off", core_rst, 0);
    sw_en = 1'b1;
    dip(TB);
    chk(core_rst == 1'b1, "R3 sw on", core_rst, 1);
    count_release(n);

    mode = 2'b10; slp = 1'b1; sw_en = 1'b1;
    dip(10);
    chk(core_rst == 1'b0, "R4 asleep", core_rst, 0);
    slp = 1'b0; sw_en = 1'b0;
    dip(TB);
    chk(core_rst == 1'b1, "R4 awake sw ignored", core_rst, 1);
    count_release(n);
    chk(core_rst == 1'b0, "R4 recovers", core_rst, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule